// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of 32 general-purpose I/O pins controlled through a simple 32-bit memory-mapped register port. Each pin has its own output value and its own direction bit. Every pin input is resynchronised to the bank clock, and the result can be read back as input data.

Each pin has four trigger conditions, and each one is enabled on its own: low level, high level, rising edge and falling edge. The enabled conditions are ORed together. When any of them occurs, the pin's pending bit is set, and it stays set until software clears it by writing a one to it. The bank combines all pending bits into a single interrupt line, masked by the interrupt enables. It also combines them into a single wake-up request line, masked by a separate set of wake enables.

Output data, interrupt enable and wake enable each have a set alias and a clear alias. Software can therefore change single bits without a read-modify-write sequence.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, these registers read zero: output data, interrupt enable, wake enable, all four detect enables, pending status, configuration and control. Direction reads all ones. The version word at 0x00 returns the major number in bits [7:4] and the minor number in bits [3:0]. The status word at 0x14 reads 1. At reset, irq_o and wake_o are low.
- R2: `pin_o` always equals the output-data register. `pin_drv_en_o` is the bitwise inverse of the direction register at 0x34, so a direction bit of 1 means the pin is an input and its driver is off.
- R3: The input-data register at 0x38 reads `pin_i` after two synchronising flops. A pin change sampled at clock edge n is visible after edge n+1.
- R4: Some offsets are aliases. For output data: 0x94 sets bits and 0x90 clears them. For interrupt enable: 0x64 sets and 0x60 clears. For wake enable: 0x84 sets and 0x80 clears. In an alias write, a 1 bit sets or clears the matching bit and a 0 bit leaves it unchanged. Reading an alias address returns the underlying register.
- R5: The level-low enables are at 0x40 and the level-high enables at 0x44. On every cycle that the synchronised pin is at an enabled level, the pending bit is set again. Clearing the bit while the level is still present therefore leaves it pending one cycle later.
- R6: The rising-edge enables are at 0x48 and the falling-edge enables at 0x4C. An edge is found by comparing two consecutive synchronised samples, so one pin transition sets the pending bit exactly once.
- R7: Writing a mask to 0x18 clears each pending bit whose mask bit is 1, and leaves the other bits alone. If a clear and a new event hit the same bit in the same cycle, the event wins and the bit stays set.
- R8: A pending bit latches even while its interrupt enable is 0. `irq_o` is the OR over all pins of (pending AND interrupt enable).
- R9: `wake_o` is the OR over all pins of (pending AND wake enable).
- R10: Writes to undefined offsets have no effect, and reads of undefined offsets return 0. Writes to the read-only words at 0x00, 0x14 and 0x38 are ignored.
- R11: A plain write stores the full value at each of these offsets: configuration at 0x10, interrupt enable at 0x1C, control at 0x30, direction at 0x34, output data at 0x3C, and the four detect-enable words at 0x40, 0x44, 0x48 and 0x4C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bank clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe; the write takes effect at the next clock edge |
| bus_addr_i | input | 8 | Byte offset of the register being accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pin_i | input | 32 | Asynchronous pin inputs |
| pin_o | output | 32 | Pin output values |
| pin_drv_en_o | output | 32 | Per-pin driver enable, 1 means the pin is driven |
| irq_o | output | 1 | Bank interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
Most corrupted internal state in this block shows up at the ports within one clock. A wrong enable or pending bit changes `irq_o`, `wake_o` or the read data on the very next comparison. A wrong output or direction bit appears directly on `pin_o` or `pin_drv_en_o`. A mistake in the synchroniser depth or in the previous-sample register shows up only as timing: input data arrives a cycle early or late, or a pending bit is set one cycle off. For that reason the reference model is compared on every clock, not only at chosen points. The same-cycle race between a clear write and a new event is provoked on purpose, so that a wrong priority is visible at the status word.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_DW = 32;
  localparam int BUS_AW = 8;

  typedef enum logic [3:0] {
    R_NONE, R_REV, R_SYSCFG, R_SYSSTAT, R_STATUS, R_IEN, R_CTRL, R_OE,
    R_DIN, R_DOUT, R_LVL_LO, R_LVL_HI, R_RISE, R_FALL, R_WEN
  } reg_sel_e;

  typedef enum logic [1:0] {OP_WR, OP_CLR, OP_SET} wr_op_e;

  typedef struct packed {
    reg_sel_e sel;
    wr_op_e   op;
  } dec_t;

  // offsets are software-visible; aliases share the target register
  function automatic dec_t decode(input logic [BUS_AW-1:0] a);
    dec_t d;
    d = '{sel: R_NONE, op: OP_WR};
    case (a)
      8'h00: d.sel = R_REV;
      8'h10: d.sel = R_SYSCFG;
      8'h14: d.sel = R_SYSSTAT;
      8'h18: d.sel = R_STATUS;
      8'h1C: d.sel = R_IEN;
      8'h30: d.sel = R_CTRL;
      8'h34: d.sel = R_OE;
      8'h38: d.sel = R_DIN;
      8'h3C: d.sel = R_DOUT;
      8'h40: d.sel = R_LVL_LO;
      8'h44: d.sel = R_LVL_HI;
      8'h48: d.sel = R_RISE;
      8'h4C: d.sel = R_FALL;
      8'h60: d = '{sel: R_IEN,  op: OP_CLR};
      8'h64: d = '{sel: R_IEN,  op: OP_SET};
      8'h80: d = '{sel: R_WEN,  op: OP_CLR};
      8'h84: d = '{sel: R_WEN,  op: OP_SET};
      8'h90: d = '{sel: R_DOUT, op: OP_CLR};
      8'h94: d = '{sel: R_DOUT, op: OP_SET};
      default: d = '{sel: R_NONE, op: OP_WR};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  // one more sample for edge comparison
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign cur_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] lo_en_i,
  input  logic [W-1:0] hi_en_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] evt;
  logic [W-1:0] status_q;

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic lvl_hit, edge_hit;
    assign lvl_hit  = (lo_en_i[g] & ~cur_i[g]) | (hi_en_i[g] & cur_i[g]);
    assign edge_hit = (rise_en_i[g] & cur_i[g] & ~prev_i[g])
                    | (fall_en_i[g] & ~cur_i[g] & prev_i[g]);
    assign evt[g]   = lvl_hit | edge_hit;
  end

  // new event overrides a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | evt;
  end

  assign status_o = status_q;

  a_r5_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((status_o & $past(evt)) == $past(evt)));

  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~evt) != '0) |=> ((status_o & $past(clr_i & ~evt)) == '0));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != '0) |=> ((~status_o & $past(status_o & ~clr_i)) == '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int         W         = 32,
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  output logic [BUS_DW-1:0] rdata_o,
  input  logic [W-1:0]      din_i,
  input  logic [W-1:0]      status_i,
  output logic [W-1:0]      oe_o,
  output logic [W-1:0]      dout_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      wen_o,
  output logic [W-1:0]      lo_en_o,
  output logic [W-1:0]      hi_en_o,
  output logic [W-1:0]      rise_en_o,
  output logic [W-1:0]      fall_en_o,
  output logic [W-1:0]      stat_clr_o
);

  localparam int DW = BUS_DW;

  dec_t         dec;
  logic [W-1:0] wd;
  logic [W-1:0] oe_q, dout_q, ien_q, wen_q, lo_q, hi_q, rise_q, fall_q;
  logic [DW-1:0] syscfg_q, ctrl_q;

  assign dec = decode(addr_i);
  assign wd  = wdata_i[W-1:0];

  function automatic logic [W-1:0] upd(input logic [W-1:0] cur,
                                       input logic [W-1:0] val,
                                       input wr_op_e       op);
    case (op)
      OP_CLR:  return cur & ~val;
      OP_SET:  return cur | val;
      default: return val;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q     <= '1;
      dout_q   <= '0;
      ien_q    <= '0;
      wen_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      syscfg_q <= '0;
      ctrl_q   <= '0;
    end else if (we_i) begin
      case (dec.sel)
        R_SYSCFG: syscfg_q <= wdata_i;
        R_CTRL:   ctrl_q   <= wdata_i;
        R_OE:     oe_q     <= wd;
        R_DOUT:   dout_q   <= upd(dout_q, wd, dec.op);
        R_IEN:    ien_q    <= upd(ien_q, wd, dec.op);
        R_WEN:    wen_q    <= upd(wen_q, wd, dec.op);
        R_LVL_LO: lo_q     <= wd;
        R_LVL_HI: hi_q     <= wd;
        R_RISE:   rise_q   <= wd;
        R_FALL:   fall_q   <= wd;
        default: ;
      endcase
    end
  end

  assign stat_clr_o = (we_i && dec.sel == R_STATUS) ? wd : '0;

  always_comb begin
    rdata_o = '0;
    case (dec.sel)
      R_REV:     rdata_o = DW'({REV_MAJOR, REV_MINOR});
      R_SYSCFG:  rdata_o = syscfg_q;
      R_SYSSTAT: rdata_o = DW'(1'b1);
      R_STATUS:  rdata_o = DW'(status_i);
      R_IEN:     rdata_o = DW'(ien_q);
      R_CTRL:    rdata_o = ctrl_q;
      R_OE:      rdata_o = DW'(oe_q);
      R_DIN:     rdata_o = DW'(din_i);
      R_DOUT:    rdata_o = DW'(dout_q);
      R_LVL_LO:  rdata_o = DW'(lo_q);
      R_LVL_HI:  rdata_o = DW'(hi_q);
      R_RISE:    rdata_o = DW'(rise_q);
      R_FALL:    rdata_o = DW'(fall_q);
      R_WEN:     rdata_o = DW'(wen_q);
      default:   rdata_o = '0;
    endcase
  end

  assign oe_o      = oe_q;
  assign dout_o    = dout_q;
  assign ien_o     = ien_q;
  assign wen_o     = wen_q;
  assign lo_en_o   = lo_q;
  assign hi_en_o   = hi_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;

  a_r4_dout_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h94) |=> ((dout_o & $past(wd)) == $past(wd)));

  a_r4_ien_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h60) |=> ((ien_o & $past(wd)) == '0));

  a_r10_undef_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && dec.sel == R_NONE) |=>
      ($stable(oe_o) && $stable(dout_o) && $stable(ien_o) && $stable(wen_o)));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int         NUM_PINS    = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] REV_MAJOR   = 4'd2,
  parameter logic [3:0] REV_MINOR   = 4'd1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [BUS_AW-1:0]   bus_addr_i,
  input  logic [BUS_DW-1:0]   bus_wdata_i,
  output logic [BUS_DW-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_drv_en_o,
  output logic                irq_o,
  output logic                wake_o
);

  localparam int W = NUM_PINS;

  logic [W-1:0] cur, prev, status;
  logic [W-1:0] oe, dout, ien, wen, lo_en, hi_en, rise_en, fall_en, stat_clr;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  gpio_detect #(.W(W)) i_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cur_i     (cur),
    .prev_i    (prev),
    .lo_en_i   (lo_en),
    .hi_en_i   (hi_en),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .clr_i     (stat_clr),
    .status_o  (status)
  );

  gpio_regs #(.W(W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .din_i      (cur),
    .status_i   (status),
    .oe_o       (oe),
    .dout_o     (dout),
    .ien_o      (ien),
    .wen_o      (wen),
    .lo_en_o    (lo_en),
    .hi_en_o    (hi_en),
    .rise_en_o  (rise_en),
    .fall_en_o  (fall_en),
    .stat_clr_o (stat_clr)
  );

  assign pin_o        = dout;
  assign pin_drv_en_o = ~oe;
  assign irq_o        = |(status & ien);
  assign wake_o       = |(status & wen);

  a_r8_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status != '0 && ien != '0));

  a_r9_wake_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (wen != '0));

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, drv_en;
  logic        irq, wake;

  int    vectors = 0;
  int    miscompares = 0;
  bit    run = 1'b0;
  bit    done = 1'b0;
  string phase_req = "R1";

  // reference model state
  bit [31:0] m_oe, m_dout, m_ien, m_wen, m_lo, m_hi, m_ri, m_fa, m_st, m_cfg, m_ctl;
  bit [31:0] hist[$];

  always #4 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .pin_i        (pin_in),
    .pin_o        (pin_out),
    .pin_drv_en_o (drv_en),
    .irq_o        (irq),
    .wake_o       (wake)
  );

  function automatic bit [31:0] synced();
    return (hist.size() >= 2) ? hist[hist.size()-2] : 32'h0;
  endfunction

  function automatic bit [31:0] mrd(input bit [7:0] a);
    case (a)
      8'h00: return 32'h21;
      8'h10: return m_cfg;
      8'h14: return 32'h1;
      8'h18: return m_st;
      8'h1C, 8'h60, 8'h64: return m_ien;
      8'h30: return m_ctl;
      8'h34: return m_oe;
      8'h38: return synced();
      8'h3C, 8'h90, 8'h94: return m_dout;
      8'h40: return m_lo;
      8'h44: return m_hi;
      8'h48: return m_ri;
      8'h4C: return m_fa;
      8'h80, 8'h84: return m_wen;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_oe = '1; m_dout = 0; m_ien = 0; m_wen = 0; m_lo = 0; m_hi = 0;
      m_ri = 0; m_fa = 0; m_st = 0; m_cfg = 0; m_ctl = 0;
      hist.delete();
    end else begin
      bit [31:0] s, p, ev, clr;
      s   = (hist.size() >= 2) ? hist[hist.size()-2] : 32'h0;
      p   = (hist.size() >= 3) ? hist[hist.size()-3] : 32'h0;
      ev  = (m_lo & ~s) | (m_hi & s) | (m_ri & s & ~p) | (m_fa & ~s & p);
      clr = (we && addr == 8'h18) ? wdata : 32'h0;
      m_st = (m_st & ~clr) | ev;  // event beats clear (R7)
      if (we) begin
        case (addr)
          8'h10: m_cfg = wdata;
          8'h1C: m_ien = wdata;
          8'h30: m_ctl = wdata;
          8'h34: m_oe = wdata;
          8'h3C: m_dout = wdata;
          8'h40: m_lo = wdata;
          8'h44: m_hi = wdata;
          8'h48: m_ri = wdata;
          8'h4C: m_fa = wdata;
          8'h60: m_ien &= ~wdata;
          8'h64: m_ien |= wdata;
          8'h80: m_wen &= ~wdata;
          8'h84: m_wen |= wdata;
          8'h90: m_dout &= ~wdata;
          8'h94: m_dout |= wdata;
          default: ;
        endcase
      end
      hist.push_back(pin_in);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s addr=%h act=%h exp=%h t=%0t", tag, addr, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run && !done) begin
      chk(pin_out, m_dout, "R2 pin_o");
      chk(drv_en, ~m_oe, "R2 pin_drv_en_o");
      chk({31'b0, irq}, {31'b0, |(m_st & m_ien)}, "R8 irq_o");
      chk({31'b0, wake}, {31'b0, |(m_st & m_wen)}, "R9 wake_o");
      chk(rdata, mrd(addr), phase_req);
    end
  end

  task automatic drive(input bit w, input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    #1;
    we = w; addr = a; wdata = d;
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    drive(1'b1, a, d);
  endtask

  task automatic rd(input bit [7:0] a);
    drive(1'b0, a, 32'h0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state at the ports while reset is held
    chk(pin_out, 32'h0, "R1 pin_o in reset");
    chk(drv_en, 32'h0, "R1 drv_en in reset");
    chk({30'b0, irq, wake}, 32'h0, "R1 irq/wake in reset");
    @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;

    // R1: reset values through the register port
    phase_req = "R1";
    foreach (hist[i]) ;
    rd(8'h00); rd(8'h14); rd(8'h34); rd(8'h3C); rd(8'h1C); rd(8'h18);
    rd(8'h40); rd(8'h44); rd(8'h48); rd(8'h4C); rd(8'h80); rd(8'h10); rd(8'h30);

    // R11 plain writes, R2 pin outputs
    phase_req = "R11";
    wr(8'h34, 32'hFFFF_0000); rd(8'h34);
    wr(8'h3C, 32'h1234_5678); rd(8'h3C);
    wr(8'h10, 32'hA5A5_0001); rd(8'h10);
    wr(8'h30, 32'h0000_00C3); rd(8'h30);
    wr(8'h1C, 32'h0000_FFFF); rd(8'h1C);

    // R4 set/clear aliases and alias reads
    phase_req = "R4";
    wr(8'h94, 32'h0000_000F); rd(8'h94);
    wr(8'h90, 32'h0000_0010); rd(8'h90);
    wr(8'h90, 32'h0000_0000); rd(8'h3C);
    wr(8'h60, 32'h0000_FFFF); rd(8'h64);
    wr(8'h64, 32'h0000_0100); rd(8'h60);
    wr(8'h84, 32'h0000_0002); rd(8'h80);
    wr(8'h80, 32'h0000_0000); rd(8'h84);

    // R3 input synchronisation
    phase_req = "R3";
    rd(8'h38); pin_in = 32'hCAFE_0000;
    rd(8'h38); rd(8'h38); rd(8'h38);
    pin_in = 32'h0000_0000;
    rd(8'h38); rd(8'h38); rd(8'h38);

    // R5 level high on pin 0, latched with enable off (R8)
    phase_req = "R5";
    wr(8'h44, 32'h0000_0001);
    pin_in = 32'h0000_0001;
    rd(8'h18); rd(8'h18); rd(8'h18);
    wr(8'h64, 32'h0000_0001); rd(8'h18);
    wr(8'h18, 32'h0000_0001); rd(8'h18); rd(8'h18);
    pin_in = 32'h0;
    rd(8'h18); rd(8'h18);
    wr(8'h44, 32'h0); wr(8'h18, 32'h0000_0001); rd(8'h18); rd(8'h18);

    // R5 level low on pin 3
    wr(8'h40, 32'h0000_0008); rd(8'h18); rd(8'h18);
    wr(8'h40, 32'h0); wr(8'h18, 32'h0000_0008); rd(8'h18);

    // R6 rising on pin 1, falling on pin 2
    phase_req = "R6";
    wr(8'h48, 32'h0000_0002); wr(8'h4C, 32'h0000_0004);
    wr(8'h64, 32'h0000_0006);
    pin_in = 32'h0000_0006;
    rd(8'h18); rd(8'h18); rd(8'h18);
    wr(8'h18, 32'h0000_0002); rd(8'h18); rd(8'h18); rd(8'h18);
    pin_in = 32'h0;
    rd(8'h18); rd(8'h18); rd(8'h18);
    wr(8'h18, 32'h0000_0004); rd(8'h18); rd(8'h18);

    // R9 wake on pin 1 rising
    phase_req = "R9";
    wr(8'h84, 32'h0000_0002);
    pin_in = 32'h0000_0002;
    rd(8'h18); rd(8'h18); rd(8'h18);
    wr(8'h80, 32'h0000_0002); rd(8'h18);
    wr(8'h84, 32'h0000_0002); rd(8'h18);

    // R7 clear-all with zeros no effect, then clear and event in the same cycle
    phase_req = "R7";
    wr(8'h18, 32'h0); rd(8'h18);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18);
    wr(8'h48, 32'h0000_0010);
    rd(8'h18); pin_in = 32'h0000_0012;   // sampled at the next edge
    rd(8'h18);                           // sync stage 2
    wr(8'h18, 32'h0000_0010);            // clear meets rising event on pin 4
    rd(8'h18); rd(8'h18);
    wr(8'h18, 32'h0000_0010); rd(8'h18);

    // R10 undefined offsets and read-only words
    phase_req = "R10";
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04);
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50);
    wr(8'hFC, 32'hFFFF_FFFF); rd(8'hFC);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00);
    wr(8'h14, 32'h0); rd(8'h14);
    wr(8'h38, 32'hFFFF_FFFF); rd(8'h38);
    rd(8'h3C); rd(8'h34); rd(8'h1C);

    // mixed traffic: every requirement against the model each cycle
    phase_req = "R8 mixed";
    for (int i = 0; i < 600; i++) begin
      bit [7:0] a;
      case ($urandom % 22)
        0: a = 8'h18;  1: a = 8'h1C;  2: a = 8'h34;  3: a = 8'h3C;
        4: a = 8'h40;  5: a = 8'h44;  6: a = 8'h48;  7: a = 8'h4C;
        8: a = 8'h60;  9: a = 8'h64; 10: a = 8'h80; 11: a = 8'h84;
       12: a = 8'h90; 13: a = 8'h94; 14: a = 8'h38; 15: a = 8'h10;
       16: a = 8'h30; 17: a = 8'h08; 18: a = 8'h00; 19: a = 8'h14;
       20: a = 8'h18; default: a = 8'hA0;
      endcase
      drive(($urandom % 3) == 0, a, $urandom);
      if (($urandom % 4) == 0) pin_in = $urandom;
    end

    rd(8'h18); rd(8'h18);
    finish_run();
  end

endmodule